// File: doc/BRIEF.md
# Device-Range Block Transfer Engine

This block carries vectors between a local memory and a group of devices that all share one internal address map. One command names the operation, a device range, an internal address window and a base word in local memory. The engine then walks the range one word at a time over a simple valid/ready device bus. Devices are visited in ascending order, and within each device the addresses also ascend.

There are three operations. A broadcast sends one vector to the same window of every device in the range. A scatter cuts one long vector into slices, each as long as the window, and gives each device its own slice. A gather reads the window from each device in turn and packs the results back to back in local memory. A command with an empty range or the reserved code is refused with a one-cycle error pulse. A finished transfer ends with a one-cycle done pulse.

Top module: `xfer_engine`

## Requirements
- R1: Broadcast (cmd_op = 2'b00): every device from cmd_dev_first to cmd_dev_last receives, at each internal address a from cmd_addr_first to cmd_addr_last, the local word at cmd_base + (a - cmd_addr_first). Each such write is one accepted bus cycle with bus_we = 1.
- R2: Scatter (cmd_op = 2'b01): the j-th device of the range (j = 0 for the first) receives at address a the local word at cmd_base + j*L + (a - cmd_addr_first), where L = cmd_addr_last - cmd_addr_first + 1.
- R3: Gather (cmd_op = 2'b10): each accepted read (bus_we = 0) of device j at address a writes bus_rdata to local address cmd_base + j*L + (a - cmd_addr_first) in the same cycle through lm_wr_en. The engine raises lm_wr_en at no other time.
- R4: Bus cycles run with devices in ascending order from the first device. Within a device, addresses run in ascending order from the first address. Exactly (devices x L) cycles are accepted.
- R5: A command with cmd_dev_last < cmd_dev_first or cmd_addr_last < cmd_addr_first is accepted and refused. err is high for exactly the cycle after acceptance, no bus cycle is issued, and cmd_ready stays high.
- R6: The reserved code cmd_op = 2'b11 is refused in the same way as R5.
- R7: While bus_valid is high and bus_ready is low, the engine holds bus_valid, bus_dev, bus_addr, bus_we and lm_rd_addr unchanged into the next cycle.
- R8: done is high for exactly one cycle, the cycle after the final word is accepted. In that same cycle cmd_ready is high again.
- R9: While a transfer runs, cmd_ready is low. A command presented then is not taken and does not alter the running transfer.
- R10: After reset, cmd_ready = 1 and bus_valid, done, err and lm_wr_en are all 0.
- R11: A command with one device and one address is legal and issues exactly one bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 2 | 00 broadcast, 01 scatter, 10 gather, 11 reserved |
| cmd_dev_first | input | DEV_W | First device index |
| cmd_dev_last | input | DEV_W | Last device index |
| cmd_addr_first | input | ADDR_W | First internal address |
| cmd_addr_last | input | ADDR_W | Last internal address |
| cmd_base | input | LM_AW | Base word in local memory |
| bus_valid | output | 1 | Device bus cycle pending |
| bus_ready | input | 1 | Device accepts the cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_dev | output | DEV_W | Selected device |
| bus_addr | output | ADDR_W | Internal address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready |
| lm_rd_addr | output | LM_AW | Local memory read address (combinational read) |
| lm_rd_data | input | DATA_W | Local memory read data |
| lm_wr_en | output | 1 | Local memory write strobe |
| lm_wr_addr | output | LM_AW | Local memory write address |
| lm_wr_data | output | DATA_W | Local memory write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
The assertions check four things on every cycle. The bus cycle must not move during a stall. The address must stay inside the command window. done and err must be single pulses that leave the engine idle and the bus quiet. cmd_ready must be low whenever a bus cycle is pending, and local writes may happen only on accepted reads. Only the bench scenarios can show that each word lands on the right device and address and at the right local offset, because that depends on the whole command. The same holds for the device order, for refusing the reserved code and empty ranges, and for a command offered while busy leaving the running transfer intact.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    OP_BCAST   = 2'b00,
    OP_SCATTER = 2'b01,
    OP_GATHER  = 2'b10,
    OP_RSVD    = 2'b11
  } xfer_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xfer_cmd_check.sv
module xfer_cmd_check
  import xfer_pkg::*;
#(
  parameter int DEV_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        op,
  input  logic [DEV_W-1:0]  dev_first,
  input  logic [DEV_W-1:0]  dev_last,
  input  logic [ADDR_W-1:0] addr_first,
  input  logic [ADDR_W-1:0] addr_last,
  output logic              cmd_ok
);
  logic op_ok, dev_ok, addr_ok;

  always_comb begin
    op_ok   = (op != OP_RSVD);
    dev_ok  = (dev_last >= dev_first);
    addr_ok = (addr_last >= addr_first);
    cmd_ok  = op_ok && dev_ok && addr_ok;
  end
endmodule

// File: rtl/xfer_walker.sv
module xfer_walker #(
  parameter int DEV_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic              step,
  input  logic [DEV_W-1:0]  dev_first,
  input  logic [DEV_W-1:0]  dev_last,
  input  logic [ADDR_W-1:0] addr_first,
  input  logic [ADDR_W-1:0] addr_last,
  output logic [DEV_W-1:0]  dev_cur,
  output logic [ADDR_W-1:0] addr_cur,
  output logic              slice_end,
  output logic              final_word
);
  logic [DEV_W-1:0]  dev_q, dev_d, dlast_q, dlast_d;
  logic [ADDR_W-1:0] addr_q, addr_d, alo_q, alo_d, ahi_q, ahi_d;

  assign slice_end  = (addr_q == ahi_q);
  assign final_word = slice_end && (dev_q == dlast_q);
  assign dev_cur    = dev_q;
  assign addr_cur   = addr_q;

  always_comb begin
    dev_d   = dev_q;
    addr_d  = addr_q;
    dlast_d = dlast_q;
    alo_d   = alo_q;
    ahi_d   = ahi_q;
    if (load) begin
      dev_d   = dev_first;
      addr_d  = addr_first;
      dlast_d = dev_last;
      alo_d   = addr_first;
      ahi_d   = addr_last;
    end else if (step) begin
      if (slice_end) begin
        addr_d = alo_q;
        dev_d  = dev_q + 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q   <= '0;
      addr_q  <= '0;
      dlast_q <= '0;
      alo_q   <= '0;
      ahi_q   <= '0;
    end else if (load || step) begin
      dev_q   <= dev_d;
      addr_q  <= addr_d;
      dlast_q <= dlast_d;
      alo_q   <= alo_d;
      ahi_q   <= ahi_d;
    end
  end

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (addr_q >= alo_q) && (addr_q <= ahi_q) && (dev_q <= dlast_q));
endmodule

// File: rtl/xfer_lptr.sv
module xfer_lptr #(
  parameter int LM_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             rewind,
  input  logic             slice_end,
  input  logic [LM_AW-1:0] base,
  output logic [LM_AW-1:0] ptr
);
  logic [LM_AW-1:0] ptr_q, ptr_d, base_q, base_d;

  always_comb begin
    ptr_d  = ptr_q;
    base_d = base_q;
    if (load) begin
      ptr_d  = base;
      base_d = base;
    end else if (step) begin
      if (rewind && slice_end) ptr_d = base_q;
      else                     ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (load || step) begin
      ptr_q  <= ptr_d;
      base_q <= base_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int DEV_W  = 4,
  parameter int ADDR_W = 8,
  parameter int LM_AW  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DEV_W-1:0]  cmd_dev_first,
  input  logic [DEV_W-1:0]  cmd_dev_last,
  input  logic [ADDR_W-1:0] cmd_addr_first,
  input  logic [ADDR_W-1:0] cmd_addr_last,
  input  logic [LM_AW-1:0]  cmd_base,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [DEV_W-1:0]  bus_dev,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [LM_AW-1:0]  lm_rd_addr,
  input  logic [DATA_W-1:0] lm_rd_data,
  output logic              lm_wr_en,
  output logic [LM_AW-1:0]  lm_wr_addr,
  output logic [DATA_W-1:0] lm_wr_data,
  output logic              done,
  output logic              err
);
  logic        rst_s;
  xfer_state_e state_q, state_d;
  xfer_op_e    op_q, op_d;
  logic        done_q, done_d, err_q, err_d;
  logic        cmd_ok, accept, load, step, finish;
  logic        slice_end, final_word, running;
  logic [LM_AW-1:0] ptr;

  xfer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  xfer_cmd_check #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_chk (
    .op(cmd_op), .dev_first(cmd_dev_first), .dev_last(cmd_dev_last),
    .addr_first(cmd_addr_first), .addr_last(cmd_addr_last), .cmd_ok(cmd_ok)
  );

  assign running   = (state_q == ST_RUN);
  assign cmd_ready = !running;
  assign accept    = cmd_valid && cmd_ready;
  assign load      = accept && cmd_ok;
  assign step      = running && bus_ready;
  assign finish    = step && final_word;

  xfer_walker #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_s), .active(running), .load(load), .step(step),
    .dev_first(cmd_dev_first), .dev_last(cmd_dev_last),
    .addr_first(cmd_addr_first), .addr_last(cmd_addr_last),
    .dev_cur(bus_dev), .addr_cur(bus_addr),
    .slice_end(slice_end), .final_word(final_word)
  );

  xfer_lptr #(.LM_AW(LM_AW)) u_ptr (
    .clk(clk), .rst_n(rst_s), .load(load), .step(step),
    .rewind(op_q == OP_BCAST), .slice_end(slice_end),
    .base(cmd_base), .ptr(ptr)
  );

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_ok) begin
            state_d = ST_RUN;
            op_d    = xfer_op_e'(cmd_op);
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (finish) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      op_q    <= OP_BCAST;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (load) op_q <= op_d;
    end
  end

  assign bus_valid  = running;
  assign bus_we     = (op_q != OP_GATHER);
  assign bus_wdata  = lm_rd_data;
  assign lm_rd_addr = ptr;
  assign lm_wr_en   = step && (op_q == OP_GATHER);
  assign lm_wr_addr = ptr;
  assign lm_wr_data = bus_rdata;
  assign done       = done_q;
  assign err        = err_q;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_dev) && $stable(bus_addr)
                                && $stable(bus_we) && $stable(lm_rd_addr));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> cmd_ready && !bus_valid && !err);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    err |-> cmd_ready && !bus_valid && !done);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    bus_valid |-> !cmd_ready);
  // R3
  lm_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    lm_wr_en |-> bus_valid && bus_ready && !bus_we);
endmodule

// File: tb/sim_xfer_engine.sv
module sim_xfer_engine;
  localparam int DEV_W = 4, ADDR_W = 8, LM_AW = 10, DATA_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic cmd_valid, cmd_ready;
  logic [1:0] cmd_op;
  logic [DEV_W-1:0] cmd_dev_first, cmd_dev_last;
  logic [ADDR_W-1:0] cmd_addr_first, cmd_addr_last;
  logic [LM_AW-1:0] cmd_base;
  logic bus_valid, bus_ready, bus_we;
  logic [DEV_W-1:0] bus_dev;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic [LM_AW-1:0] lm_rd_addr, lm_wr_addr;
  logic [DATA_W-1:0] lm_rd_data, lm_wr_data;
  logic lm_wr_en, done, err;

  logic [DATA_W-1:0] lmem [0:(1<<LM_AW)-1];
  logic [7:0] lfsr = 8'hA5;
  logic stall_en = 1'b0;

  function automatic logic [DATA_W-1:0] devval(int d, int a);
    return DATA_W'((d * 16'h0400) ^ (a * 3) ^ 16'h1234);
  endfunction

  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign bus_ready  = !stall_en || lfsr[0];
  assign lm_rd_data = lmem[lm_rd_addr];
  assign bus_rdata  = devval(int'(bus_dev), int'(bus_addr));

  xfer_engine #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .LM_AW(LM_AW), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev_first(cmd_dev_first), .cmd_dev_last(cmd_dev_last),
    .cmd_addr_first(cmd_addr_first), .cmd_addr_last(cmd_addr_last), .cmd_base(cmd_base),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we), .bus_dev(bus_dev),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lm_rd_addr(lm_rd_addr), .lm_rd_data(lm_rd_data), .lm_wr_en(lm_wr_en),
    .lm_wr_addr(lm_wr_addr), .lm_wr_data(lm_wr_data), .done(done), .err(err)
  );

  int tests = 0, fails = 0;
  int e_op, e_df, e_af, e_al, e_base, e_dev, e_addr;
  int cyc = 0, hs_cnt, order_err, data_err, stall_err, stall_seen, done_cnt, done_cyc, last_hs_cyc;
  logic st_prev = 1'b0;
  logic [DEV_W-1:0] p_dev;
  logic [ADDR_W-1:0] p_addr;
  logic [LM_AW-1:0] p_lra;
  logic p_we;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bus monitor: order (R4), data placement (R1, R2, R3), stall hold (R7), done timing (R8)
  always @(negedge clk) begin
    cyc++;
    if (st_prev) begin
      if (!(bus_valid && bus_dev == p_dev && bus_addr == p_addr && bus_we == p_we && lm_rd_addr == p_lra))
        stall_err++;
    end
    if (bus_valid && !bus_ready) stall_seen++;
    st_prev = bus_valid && !bus_ready;
    p_dev = bus_dev; p_addr = bus_addr; p_we = bus_we; p_lra = lm_rd_addr;
    if (lm_wr_en && !(bus_valid && bus_ready)) data_err++;
    if (bus_valid && bus_ready) begin
      int j, off, idx;
      if (int'(bus_dev) != e_dev || int'(bus_addr) != e_addr) order_err++;
      j   = int'(bus_dev) - e_df;
      off = int'(bus_addr) - e_af;
      idx = (e_base + ((e_op == 0) ? 0 : j * (e_al - e_af + 1)) + off) % (1 << LM_AW);
      if (e_op == 2) begin
        if (bus_we || !lm_wr_en || int'(lm_wr_addr) != idx ||
            lm_wr_data != devval(int'(bus_dev), int'(bus_addr))) data_err++;
      end else begin
        if (!bus_we || lm_wr_en || bus_wdata != lmem[idx]) data_err++;
      end
      if (e_addr == e_al) begin e_addr = e_af; e_dev++; end
      else e_addr++;
      hs_cnt++;
      last_hs_cyc = cyc;
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (lm_wr_en) lmem[lm_wr_addr] = lm_wr_data;
  end

  task automatic arm(input int op, input int df, input int af, input int al, input int base);
    e_op = op; e_df = df; e_af = af; e_al = al; e_base = base;
    e_dev = df; e_addr = af;
    hs_cnt = 0; order_err = 0; data_err = 0; stall_err = 0; stall_seen = 0;
    done_cnt = 0; done_cyc = -1; last_hs_cyc = -2;
  endtask

  task automatic drive_cmd(input int op, input int df, input int dl, input int af, input int al, input int base);
    cmd_op = 2'(op); cmd_dev_first = DEV_W'(df); cmd_dev_last = DEV_W'(dl);
    cmd_addr_first = ADDR_W'(af); cmd_addr_last = ADDR_W'(al); cmd_base = LM_AW'(base);
    cmd_valid = 1'b1;
  endtask

  task automatic run_xfer(input string req, input int op, input int df, input int dl,
                          input int af, input int al, input int base, input bit stall, input bit poke);
    int waited = 0;
    @(posedge clk); #1;
    arm(op, df, af, al, base);
    stall_en = stall;
    drive_cmd(op, df, dl, af, al, base);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (poke) begin
      // R9: offer a second command while busy
      @(posedge clk); #1;
      drive_cmd(2, 0, 1, 0, 1, 0);
      @(posedge clk); #2;
      check(cmd_ready == 1'b0, "R9", "cmd_ready while busy", int'(cmd_ready), 0);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
    end
    while (done_cnt == 0 && waited < 3000) begin
      @(posedge clk); #2;
      waited++;
    end
    repeat (3) @(posedge clk);
    #2;
    check(hs_cnt == (dl - df + 1) * (al - af + 1), "R4", {req, " accepted word count"}, hs_cnt, (dl - df + 1) * (al - af + 1));
    check(data_err == 0, req, "data placement errors", data_err, 0);
    check(order_err == 0, "R4", {req, " device/address order errors"}, order_err, 0);
    check(done_cnt == 1 && done_cyc == last_hs_cyc + 1, "R8", {req, " done pulse cycle"}, done_cyc, last_hs_cyc + 1);
    check(cmd_ready == 1'b1 && bus_valid == 1'b0, "R8", {req, " idle after done"}, int'(cmd_ready), 1);
    if (stall)
      check(stall_err == 0 && stall_seen > 0, "R7", {req, " stall hold errors"}, stall_err, 0);
    stall_en = 1'b0;
  endtask

  task automatic run_bad(input string req, input int op, input int df, input int dl, input int af, input int al);
    @(posedge clk); #1;
    arm(0, df, af, al, 0);
    drive_cmd(op, df, dl, af, al, 0);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    #1;
    check(err == 1'b1 && bus_valid == 1'b0 && cmd_ready == 1'b1, req, "refusal pulse", int'(err), 1);
    @(posedge clk); #2;
    check(err == 1'b0, req, "err width", int'(err), 0);
    repeat (4) @(posedge clk);
    #2;
    check(hs_cnt == 0 && done_cnt == 0, req, "bus cycles after refusal", hs_cnt, 0);
  endtask

  task automatic test_reset();
    check(cmd_ready == 1'b1, "R10", "cmd_ready after reset", int'(cmd_ready), 1);
    check(!bus_valid && !done && !err && !lm_wr_en, "R10", "outputs quiet after reset",
          int'({bus_valid, done, err, lm_wr_en}), 0);
  endtask

  task automatic test_gather_memory();
    // R3: word of device 4 (j = 1), address 22 (off 2), slice 3 -> 500 + 3 + 2
    check(lmem[505] == devval(4, 22), "R3", "gathered word in local memory", int'(lmem[505]), int'(devval(4, 22)));
    check(lmem[500] == devval(3, 20), "R3", "first gathered word", int'(lmem[500]), int'(devval(3, 20)));
  endtask

  initial begin
    for (int i = 0; i < (1 << LM_AW); i++) lmem[i] = DATA_W'(i * 7 + 3);
    rst_n = 1'b0; cmd_valid = 1'b0;
    cmd_op = '0; cmd_dev_first = '0; cmd_dev_last = '0;
    cmd_addr_first = '0; cmd_addr_last = '0; cmd_base = '0;
    arm(0, 0, 0, 0, 0);
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        test_reset();
        run_xfer("R1", 0, 2, 5, 10, 13, 100, 1'b0, 1'b0);
        run_xfer("R2", 1, 0, 3, 0, 4, 200, 1'b1, 1'b0);
        run_xfer("R3", 2, 3, 6, 20, 22, 500, 1'b1, 1'b0);
        test_gather_memory();
        run_xfer("R1", 0, 13, 15, 250, 255, 900, 1'b1, 1'b0);
        run_xfer("R11", 1, 9, 9, 77, 77, 321, 1'b0, 1'b0);
        run_xfer("R9", 1, 1, 4, 5, 8, 40, 1'b1, 1'b1);
        run_bad("R5", 0, 6, 5, 0, 3);
        run_bad("R5", 1, 0, 3, 9, 8);
        run_bad("R6", 3, 0, 3, 0, 3);
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 1, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule